// File: doc/BRIEF.md
# Edge-Latched External Interrupt Flags

This block watches eight external interrupt pins and turns selected transitions on them into latched request flags. Each pin is first brought into the clock domain through a synchroniser. A per-pin sense setting then decides which transitions count: rising, falling or both. A detected transition sets that pin's flag. The flag stays set until the downstream priority resolver accepts it, or until software clears it. The pending flags go out to the resolver. Each pending flag carries the pin's configured priority level.

Software clears a flag with a handshake. It reads the flag vector, then writes 0 to the bits it saw as 1. A read that returns 1 for a bit arms that bit. A 0 written to an armed bit clears the flag, and a 0 written to an unarmed bit does nothing. A new transition on an armed pin disarms it again. This means a transition that lands between the read and the write always survives the write. Each pin's flag is a small state machine with three states:
- `FLG_IDLE`: no request.
- `FLG_PEND`: request latched, not yet seen by a read.
- `FLG_ARMED`: request latched and seen by a read.

The state machine has these transitions:
- edge: any state goes to `FLG_PEND`. This takes precedence over every other event.
- read: `FLG_PEND` goes to `FLG_ARMED`.
- accept: `FLG_PEND` or `FLG_ARMED` goes to `FLG_IDLE`.
- qualified clear: `FLG_ARMED` goes to `FLG_IDLE` on a write of 0 to that bit.

Any other event leaves the state unchanged.

When the resolver accepts a source, the block clears only that source's flag. On the next cycle it reports the accepted source's priority level, which the processor loads into its interrupt mask.

Top module: `extirq_edge_flags`

## Requirements
- R1: After reset, `req_o`, `rd_data_o`, `req_prio_o` and `ack_valid_o` are all zero. A pin that is already high when reset is released does not count as an edge.
- R2: Sense code 2'b10 in `sense_cfg_i[2i+1:2i]` selects rising-edge detection for pin i. A low-to-high change on the pin sets flag i. The flag appears on `req_o[i]` at the third rising clock edge after the pin changes, and not before. A high-to-low change does not set the flag.
- R3: Sense code 2'b01 selects falling-edge detection. A high-to-low change sets the flag and a low-to-high change does not.
- R4: Sense code 2'b11 sets the flag on a change in either direction.
- R5: Sense code 2'b00 disables edge detection for that pin, and the pin never sets its flag.
- R6: A set flag stays set, across any number of further edges, until it is accepted or cleared. `rd_data_o` always shows the flag vector, with bit i for pin i.
- R7: Writing 0 to a flag bit that has not been read as 1 since it was last set leaves that flag set.
- R8: After a read returns 1 for a bit, writing 0 to that bit clears the flag. Writing 1 has no effect on the flag and keeps the bit armed.
- R9: An edge that arrives after the read and before the write disarms the bit. The following write of 0 leaves the flag set.
- R10: If an edge is detected in the same cycle as a qualified clear or an acceptance of that pin, the flag stays set.
- R11: An acceptance (`ack_i` with index `ack_idx_i`) clears only the indexed flag. On the next cycle, `ack_valid_o` is 1 and `ack_level_o` holds that pin's priority level, `prio_cfg_i[4i+3:4i]`. An acceptance of a pin whose flag is clear changes nothing and leaves `ack_valid_o` at 0.
- R12: `req_prio_o[4i+3:4i]` carries pin i's priority level while flag i is set, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous interrupt pins |
| sense_cfg_i | input | 16 | Per-pin 2-bit sense code |
| prio_cfg_i | input | 32 | Per-pin 4-bit priority level |
| rd_en_i | input | 1 | Flag-vector read strobe |
| rd_data_o | output | 8 | Current flag vector |
| wr_en_i | input | 1 | Flag-vector write strobe |
| wr_data_i | input | 8 | Write data; a 0 bit requests a clear |
| ack_i | input | 1 | Acceptance strobe from the resolver |
| ack_idx_i | input | 3 | Index of the accepted pin |
| req_o | output | 8 | Latched requests toward the resolver |
| req_prio_o | output | 32 | Priority level per pending request |
| ack_valid_o | output | 1 | An acceptance hit a pending flag last cycle |
| ack_level_o | output | 4 | Priority level of the accepted source |

## Verification
A wrong per-pin state shows at the ports within one cycle of the next event that depends on it. A pin stuck in `FLG_IDLE` never raises `req_o`, three cycles after its edge. A pin wrongly in `FLG_ARMED` lets the next write of 0 drop a request that should survive, and this is visible on `rd_data_o` on the following cycle. A pin wrongly in `FLG_PEND` ignores a legitimate clear, which is also visible a cycle after the write. Errors in the synchroniser or edge path show up as a shifted latency or a wrong edge polarity at the third clock after a pin change.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'b00,
        FLG_PEND  = 2'b01,
        FLG_ARMED = 2'b11
    } flag_state_e;

    localparam logic [1:0] SENSE_OFF  = 2'b00;
    localparam logic [1:0] SENSE_FALL = 2'b01;
    localparam logic [1:0] SENSE_RISE = 2'b10;
    localparam logic [1:0] SENSE_BOTH = 2'b11;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic             sync_valid_o
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [STAGES-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
            valid_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
            valid_q <= {valid_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_o       = chain_q[STAGES-1];
    assign sync_valid_o = valid_q[STAGES-1];

endmodule

// File: rtl/extirq_edge_sense.sv
module extirq_edge_sense
    import extirq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   sync_i,
    input  logic               sync_valid_i,
    input  logic [2*WIDTH-1:0] sense_i,
    output logic [WIDTH-1:0]   edge_o
);

    logic [WIDTH-1:0] prev_q;
    logic             prev_valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q       <= '0;
            prev_valid_q <= 1'b0;
        end else begin
            prev_q       <= sync_i;
            prev_valid_q <= sync_valid_i;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic rise, fall, hit;
        assign rise = sync_i[i] & ~prev_q[i];
        assign fall = ~sync_i[i] & prev_q[i];
        always_comb begin
            unique case (sense_i[2*i +: 2])
                SENSE_RISE: hit = rise;
                SENSE_FALL: hit = fall;
                SENSE_BOTH: hit = rise | fall;
                default:    hit = 1'b0;
            endcase
        end
        assign edge_o[i] = prev_valid_q & hit;
    end

endmodule

// File: rtl/extirq_flag_fsm.sv
module extirq_flag_fsm
    import extirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic read_i,
    input  logic clear_i,
    input  logic accept_i,
    output logic pending_o,
    output logic armed_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (edge_i) state_d = FLG_PEND;
            end
            FLG_PEND: begin
                if (edge_i)        state_d = FLG_PEND;
                else if (accept_i) state_d = FLG_IDLE;
                else if (read_i)   state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (edge_i)                    state_d = FLG_PEND;
                else if (accept_i || clear_i)  state_d = FLG_IDLE;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_PEND:  begin pending_o = 1'b1; armed_o = 1'b0; end
            FLG_ARMED: begin pending_o = 1'b1; armed_o = 1'b1; end
            default:   begin pending_o = 1'b0; armed_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/extirq_edge_flags.sv
module extirq_edge_flags
    import extirq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int PRIO_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        pin_i,
    input  logic [2*NUM_PINS-1:0]      sense_cfg_i,
    input  logic [PRIO_W*NUM_PINS-1:0] prio_cfg_i,
    input  logic                       rd_en_i,
    output logic [NUM_PINS-1:0]        rd_data_o,
    input  logic                       wr_en_i,
    input  logic [NUM_PINS-1:0]        wr_data_i,
    input  logic                       ack_i,
    input  logic [IDX_W-1:0]           ack_idx_i,
    output logic [NUM_PINS-1:0]        req_o,
    output logic [PRIO_W*NUM_PINS-1:0] req_prio_o,
    output logic                       ack_valid_o,
    output logic [PRIO_W-1:0]          ack_level_o
);

    logic [NUM_PINS-1:0] sync_vec;
    logic                sync_valid;
    logic [NUM_PINS-1:0] edge_vec;
    logic [NUM_PINS-1:0] pending_vec;
    logic [NUM_PINS-1:0] armed_vec;
    logic [PRIO_W-1:0]   prio_arr [NUM_PINS];

    extirq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .async_i      (pin_i),
        .sync_o       (sync_vec),
        .sync_valid_o (sync_valid)
    );

    extirq_edge_sense #(
        .WIDTH (NUM_PINS)
    ) u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync_vec),
        .sync_valid_i (sync_valid),
        .sense_i      (sense_cfg_i),
        .edge_o       (edge_vec)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_flag
        logic clear_hit, accept_hit;
        assign clear_hit  = wr_en_i & ~wr_data_i[i];
        assign accept_hit = ack_i & (ack_idx_i == IDX_W'(i));
        assign prio_arr[i] = prio_cfg_i[PRIO_W*i +: PRIO_W];
        assign req_prio_o[PRIO_W*i +: PRIO_W] = pending_vec[i] ? prio_arr[i] : '0;

        extirq_flag_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .edge_i    (edge_vec[i]),
            .read_i    (rd_en_i),
            .clear_i   (clear_hit),
            .accept_i  (accept_hit),
            .pending_o (pending_vec[i]),
            .armed_o   (armed_vec[i])
        );
    end

    assign req_o     = pending_vec;
    assign rd_data_o = pending_vec;

    logic ack_in_range;
    assign ack_in_range = (32'(ack_idx_i) < NUM_PINS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid_o <= 1'b0;
            ack_level_o <= '0;
        end else begin
            ack_valid_o <= ack_i & ack_in_range & pending_vec[ack_idx_i];
            if (ack_i && ack_in_range) begin
                ack_level_o <= prio_arr[ack_idx_i];
            end
        end
    end

endmodule

// File: rtl/extirq_edge_flags_chk.sv
module extirq_edge_flags_chk #(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   edge_vec,
    input logic [NUM_PINS-1:0]   armed_vec,
    input logic [NUM_PINS-1:0]   req_o,
    input logic [2*NUM_PINS-1:0] sense_cfg_i,
    input logic                  rd_en_i,
    input logic                  wr_en_i,
    input logic [NUM_PINS-1:0]   wr_data_i,
    input logic                  ack_i,
    input logic [IDX_W-1:0]      ack_idx_i,
    input logic                  ack_valid_o
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        logic acc_i;
        assign acc_i = ack_i && (ack_idx_i == IDX_W'(i));

        // An edge always leaves the flag pending and unarmed.
        assert_edge_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
            edge_vec[i] |=> (req_o[i] && !armed_vec[i]));

        // A disabled pin produces no edge.
        assert_off_pin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_cfg_i[2*i +: 2] == 2'b00) |-> !edge_vec[i]);

        // A 0 written to an unarmed pending bit cannot clear it.
        assert_unarmed_clear_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[i] && !armed_vec[i] && !acc_i) |=> req_o[i]);

        // Qualified clear without a coincident edge empties the flag.
        assert_armed_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_vec[i] && wr_en_i && !wr_data_i[i] && !edge_vec[i]) |=> !req_o[i]);

        // Acceptance without a coincident edge empties the flag.
        assert_accept_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_i && !edge_vec[i]) |=> !req_o[i]);

        // A bit becomes armed only through a read.
        assert_arm_needs_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(armed_vec[i]) |-> $past(rd_en_i));

        // A pending flag survives anything but a clear or an acceptance.
        assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[i] && !acc_i && !(armed_vec[i] && wr_en_i && !wr_data_i[i])) |=> req_o[i]);
    end

    assert_ack_report_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> $past(ack_i));

endmodule

bind extirq_edge_flags extirq_edge_flags_chk #(
    .NUM_PINS (NUM_PINS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_vec    (edge_vec),
    .armed_vec   (armed_vec),
    .req_o       (req_o),
    .sense_cfg_i (sense_cfg_i),
    .rd_en_i     (rd_en_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .ack_i       (ack_i),
    .ack_idx_i   (ack_idx_i),
    .ack_valid_o (ack_valid_o)
);

// File: tb/extirq_edge_flags_tb.sv
module extirq_edge_flags_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = 8'h80;
    logic [15:0] sense_cfg_i = 16'hAAAA;
    logic [31:0] prio_cfg_i;
    logic        rd_en_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_data_i = 8'hFF;
    logic        ack_i = 1'b0;
    logic [2:0]  ack_idx_i = 3'd0;
    logic [7:0]  req_o;
    logic [31:0] req_prio_o;
    logic        ack_valid_o;
    logic [3:0]  ack_level_o;

    int checks = 0;
    int errors = 0;
    logic [7:0]  rv;
    logic [39:0] vec;

    always #5 clk = ~clk;

    extirq_edge_flags u_dut (
        .clk (clk), .rst_n (rst_n), .pin_i (pin_i), .sense_cfg_i (sense_cfg_i),
        .prio_cfg_i (prio_cfg_i), .rd_en_i (rd_en_i), .rd_data_o (rd_data_o),
        .wr_en_i (wr_en_i), .wr_data_i (wr_data_i), .ack_i (ack_i),
        .ack_idx_i (ack_idx_i), .req_o (req_o), .req_prio_o (req_prio_o),
        .ack_valid_o (ack_valid_o), .ack_level_o (ack_level_o)
    );

    // {sense, pins before, pins after, expected flags}
    localparam logic [39:0] VEC [9] = '{
        {16'hAAAA, 8'h00, 8'hFF, 8'hFF},
        {16'hAAAA, 8'hFF, 8'h00, 8'h00},
        {16'h5555, 8'h00, 8'hFF, 8'h00},
        {16'h5555, 8'hFF, 8'h00, 8'hFF},
        {16'hFFFF, 8'h0F, 8'hF0, 8'hFF},
        {16'h0000, 8'h00, 8'hFF, 8'h00},
        {16'hAA55, 8'h0F, 8'hF0, 8'hFF},
        {16'hAA55, 8'hF0, 8'h0F, 8'h00},
        {16'hC33C, 8'h00, 8'hFF, 8'h96}
    };

    initial begin
        for (int i = 0; i < 8; i++) prio_cfg_i[4*i +: 4] = 4'(i + 1);
    end

    function automatic logic [31:0] exp_prio(input logic [7:0] flags);
        logic [31:0] r = '0;
        for (int i = 0; i < 8; i++) if (flags[i]) r[4*i +: 4] = 4'(i + 1);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(output logic [7:0] d);
        rd_en_i = 1'b1;
        d = rd_data_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en_i = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        wr_data_i = 8'hFF;
    endtask

    task automatic do_ack(input logic [2:0] idx);
        ack_i = 1'b1;
        ack_idx_i = idx;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        do_read(d);
        do_write(8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        // R1: reset state; pin7 high through reset is no edge
        check("R1 req", 32'(req_o), 32'h0);
        check("R1 rd_data", 32'(rd_data_o), 32'h0);
        check("R1 prio", req_prio_o, 32'h0);
        check("R1 ack_valid", 32'(ack_valid_o), 32'h0);
        wait_n(6);
        check("R1 no reset edge", 32'(req_o), 32'h0);

        // Vector walk over sense codes (R2 R3 R4 R5)
        for (int k = 0; k < 9; k++) begin
            vec = VEC[k];
            sense_cfg_i = vec[39:24];
            pin_i = vec[23:16];
            wait_n(5);
            clear_all();
            pin_i = vec[15:8];
            wait_n(5);
            do_read(rv);
            check($sformatf("R2 R3 R4 R5 vector %0d", k), 32'(rv), 32'(vec[7:0]));
        end

        // R2: latency of exactly three clock edges
        sense_cfg_i = 16'hAAAA;
        pin_i = 8'h00;
        wait_n(5);
        clear_all();
        pin_i[0] = 1'b1;
        wait_n(2);
        check("R2 not early", 32'(req_o), 32'h0);
        wait_n(1);
        check("R2 on time", 32'(req_o), 32'h01);
        check("R12 prio of pending", req_prio_o, exp_prio(8'h01));

        // R6: further edges merge, flag holds
        pin_i[0] = 1'b0; wait_n(4);
        pin_i[0] = 1'b1; wait_n(10);
        check("R6 hold", 32'(req_o), 32'h01);

        // R7: unarmed write 0 ignored
        do_write(8'h00);
        check("R7 unarmed clear", 32'(req_o), 32'h01);

        // R8: read, write 1 no effect, then write 0 clears
        do_read(rv);
        check("R8 read value", 32'(rv), 32'h01);
        do_write(8'hFF);
        check("R8 write one", 32'(req_o), 32'h01);
        do_write(8'h00);
        check("R8 armed clear", 32'(req_o), 32'h00);

        // R9: edge between read and write survives
        pin_i[1] = 1'b1; wait_n(5);
        do_read(rv);
        pin_i[1] = 1'b0; wait_n(3);
        pin_i[1] = 1'b1; wait_n(5);
        do_write(8'h00);
        check("R9 edge after read", 32'(req_o), 32'h02);
        clear_all();
        check("R9 later clear", 32'(req_o), 32'h00);

        // R10: edge coincident with qualified clear, then with acceptance
        sense_cfg_i[5:4] = 2'b11;
        pin_i[2] = 1'b1; wait_n(5);
        do_read(rv);
        pin_i[2] = 1'b0;
        wait_n(2);
        do_write(8'h00);
        check("R10 edge vs clear", 32'(req_o), 32'h04);
        pin_i[2] = 1'b1;
        wait_n(2);
        do_ack(3'd2);
        check("R10 edge vs accept", 32'(req_o), 32'h04);
        check("R11 ack valid", 32'(ack_valid_o), 32'h1);
        check("R11 ack level", 32'(ack_level_o), 32'h3);
        do_ack(3'd2);
        check("R11 accept clears", 32'(req_o), 32'h00);

        // R11: acceptance clears only the indexed flag
        sense_cfg_i = 16'hAAAA;
        pin_i = 8'h00; wait_n(5);
        clear_all();
        pin_i = 8'hF0; wait_n(5);
        check("R2 multi pin", 32'(req_o), 32'hF0);
        do_ack(3'd5);
        check("R11 indexed", 32'(req_o), 32'hD0);
        check("R11 level pin5", 32'(ack_level_o), 32'h6);
        check("R11 valid pin5", 32'(ack_valid_o), 32'h1);
        check("R12 prio vector", req_prio_o, exp_prio(8'hD0));
        do_ack(3'd0);
        check("R11 idle accept", 32'(ack_valid_o), 32'h0);
        check("R11 idle accept flags", 32'(req_o), 32'hD0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule